// File: doc/BRIEF.md
# IOMMU Interrupt Delivery Unit

This block turns vector notifications from an IOMMU into interrupts. Software programs a table of message vectors through a 32-bit register bus. The table is mapped as a window inside the IOMMU register space, next to a read-only array of pending bits. Each notification names a vector. A run-time mode input decides how the block signals it. In wired mode it pulses one of the dedicated interrupt lines. In message mode it issues one 32-bit memory write: the vector's data word goes to the vector's 64-bit address, over a valid/ready write-request interface.

Only one message write is in flight at a time. Notifications that arrive while a write waits for acknowledgement are remembered in a per-vector pending register, and those bits are visible through the pending-bit window. Pending vectors are sent lowest index first. A second notification for a vector that is already pending merges with the first. A notification for a vector the selected mode cannot serve is dropped and reported on an error pulse.

Top module: `iommu_irq_deliver`

## Requirements
- R1: After reset every table word and the pending-bit window read zero, and `irq_pulse`, `drop_err` and `msg_valid` are low.
- R2: Vector N's entry occupies byte offsets 16*N to 16*N+15 of the window: address low word at +0, address high word at +4, data word at +8, control word at +12. A read returns data combinationally in the same cycle as `reg_valid`. A write takes effect at the clock edge.
- R3: With `reg_wide` set, the access covers two words in little-endian order. `reg_wdata[31:0]` and `reg_rdata[31:0]` belong to the word at `reg_addr`, and bits 63:32 belong to the word at `reg_addr`+4. With `reg_wide` clear, `reg_rdata[63:32]` reads zero.
- R4: The pending-bit array starts at byte offset 256. Bit N of the word at 256 is the pending flag of vector N. The word at 260 reads zero. Writes to either word have no effect.
- R5: With `wired_mode` high, a notification for vector N (N < 4) drives `irq_pulse` to exactly bit N for the single cycle after the notification is sampled.
- R6: With `wired_mode` high, a notification for vector 4 or above produces no line pulse and no write, and raises `drop_err` for one cycle.
- R7: With `wired_mode` low and no write in flight, a notification for vector N raises `msg_valid` at the second clock edge after it is sampled. At that point `msg_addr` = {address high, address low} of entry N and `msg_data` = its data word.
- R8: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` stay unchanged, even if the table is rewritten.
- R9: Notifications that arrive while a write is in flight are held as pending bits and sent one at a time in ascending vector order.
- R10: Repeated notifications for a vector that is already pending result in a single write.
- R11: With `wired_mode` low, a notification for vector 5 or above is dropped, produces no write, and raises `drop_err` for one cycle.
- R12: Window addresses outside the table and the pending-bit array read zero, and writes to them change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wired_mode | input | 1 | 1 selects line pulses, 0 selects message writes |
| ntf_valid | input | 1 | Notification strobe |
| ntf_vec | input | 3 | Vector index of the notification |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 for write, 0 for read |
| reg_wide | input | 1 | 1 for an 8-byte access, 0 for 4 bytes |
| reg_addr | input | 9 | Byte offset within the window (word aligned) |
| reg_wdata | input | 64 | Write data, little-endian |
| reg_rdata | output | 64 | Read data, valid in the access cycle |
| irq_pulse | output | 4 | Wired interrupt pulses |
| drop_err | output | 1 | One-cycle pulse for a dropped notification |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The assertions assume that `msg_ready` is only meaningful while `msg_valid` is high. They also assume that a notification and the mode input are sampled together in one cycle, so that `wired_mode` is stable while `ntf_valid` is high. The bench changes the mode only between tests. It raises `msg_ready` only after it has seen `msg_valid`, and only for a single cycle. All register addresses it uses are word aligned, and every 8-byte access is 8-byte aligned.

// File: rtl/irqdel_pkg.sv
package irqdel_pkg;

  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned ENTRY_BYTES = 16;
  localparam int unsigned ENTRY_WORDS = ENTRY_BYTES / WORD_BYTES;

  typedef enum logic [1:0] {
    FLD_ADDR_LO = 2'd0,
    FLD_ADDR_HI = 2'd1,
    FLD_DATA    = 2'd2,
    FLD_CTRL    = 2'd3
  } entry_field_e;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] data;
    logic [31:0] addr_hi;
    logic [31:0] addr_lo;
  } vec_entry_t;

  function automatic logic [31:0] entry_field(input vec_entry_t e, input logic [1:0] f);
    case (entry_field_e'(f))
      FLD_ADDR_LO: return e.addr_lo;
      FLD_ADDR_HI: return e.addr_hi;
      FLD_DATA:    return e.data;
      default:     return e.ctrl;
    endcase
  endfunction

  function automatic vec_entry_t entry_update(input vec_entry_t e, input logic [1:0] f,
                                              input logic [31:0] wd);
    vec_entry_t r;
    r = e;
    case (entry_field_e'(f))
      FLD_ADDR_LO: r.addr_lo = wd;
      FLD_ADDR_HI: r.addr_hi = wd;
      FLD_DATA:    r.data    = wd;
      default:     r.ctrl    = wd;
    endcase
    return r;
  endfunction

  function automatic logic [63:0] entry_target(input vec_entry_t e);
    return {e.addr_hi, e.addr_lo};
  endfunction

endpackage

// File: rtl/irqdel_vec_table.sv
module irqdel_vec_table
  import irqdel_pkg::*;
#(
  parameter int unsigned NUM_VEC    = 5,
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned PBA_OFFSET = 256,
  parameter int unsigned VEC_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic              reg_wide,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic [NUM_VEC-1:0] pend_bits,
  input  logic [VEC_W-1:0]  look_idx,
  output vec_entry_t        look_entry
);

  localparam int unsigned IDX_W     = ADDR_W - 2;
  localparam int unsigned TBL_WORDS = NUM_VEC * ENTRY_WORDS;
  localparam int unsigned PBA_BITS  = ((NUM_VEC + 63) / 64) * 64;
  localparam int unsigned PBA_WORDS = PBA_BITS / 32;
  localparam int unsigned PBA_BASE  = PBA_OFFSET / WORD_BYTES;
  localparam int unsigned ENT_W     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  vec_entry_t          tbl [NUM_VEC];
  logic [PBA_BITS-1:0] pba_img;
  logic [IDX_W-1:0]    lane_idx [2];
  logic                lane_we  [2];
  logic [31:0]         lane_wd  [2];
  logic [31:0]         lane_rd  [2];

  assign pba_img = PBA_BITS'(pend_bits);

  function automatic logic [31:0] read_word(input logic [IDX_W-1:0] w);
    int unsigned wi;
    wi = 32'(w);
    if (wi < TBL_WORDS)
      return entry_field(tbl[ENT_W'(wi / ENTRY_WORDS)], w[1:0]);
    else if (wi >= PBA_BASE && wi < PBA_BASE + PBA_WORDS)
      return pba_img[32*(wi - PBA_BASE) +: 32];
    else
      return 32'h0;
  endfunction

  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign lane_idx[l] = reg_addr[ADDR_W-1:2] + IDX_W'(l);
    assign lane_we[l]  = reg_valid && reg_write && ((l == 0) || reg_wide);
    assign lane_wd[l]  = reg_wdata[32*l +: 32];
    assign lane_rd[l]  = read_word(lane_idx[l]);
  end

  for (genvar e = 0; e < NUM_VEC; e++) begin : g_entry
    vec_entry_t nxt;
    always_comb begin
      nxt = tbl[e];
      for (int l = 0; l < 2; l++) begin
        if (lane_we[l] && (32'(lane_idx[l]) < TBL_WORDS) &&
            (32'(lane_idx[l]) / ENTRY_WORDS == e))
          nxt = entry_update(nxt, lane_idx[l][1:0], lane_wd[l]);
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tbl[e] <= '0;
      else        tbl[e] <= nxt;
    end
  end

  assign reg_rdata = (reg_valid && !reg_write) ?
                     {(reg_wide ? lane_rd[1] : 32'h0), lane_rd[0]} : 64'h0;

  assign look_entry = (32'(look_idx) < NUM_VEC) ? tbl[ENT_W'(look_idx)] : '0;

endmodule

// File: rtl/irqdel_notify_route.sv
module irqdel_notify_route #(
  parameter int unsigned NUM_VEC   = 5,
  parameter int unsigned NUM_WIRED = 4,
  parameter int unsigned VEC_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wired_mode,
  input  logic                 ntf_valid,
  input  logic [VEC_W-1:0]     ntf_vec,
  output logic [NUM_WIRED-1:0] irq_pulse,
  output logic                 drop_err,
  output logic [NUM_VEC-1:0]   msg_set
);

  logic                 wired_ok;
  logic                 msg_ok;
  logic                 drop_nxt;
  logic [NUM_WIRED-1:0] pulse_nxt;

  assign wired_ok = 32'(ntf_vec) < NUM_WIRED;
  assign msg_ok   = 32'(ntf_vec) < NUM_VEC;
  assign drop_nxt = ntf_valid && (wired_mode ? !wired_ok : !msg_ok);

  for (genvar i = 0; i < NUM_WIRED; i++) begin : g_wire
    assign pulse_nxt[i] = ntf_valid && wired_mode && (ntf_vec == VEC_W'(i));
  end

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_msg
    assign msg_set[i] = ntf_valid && !wired_mode && (ntf_vec == VEC_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse <= '0;
      drop_err  <= 1'b0;
    end else begin
      irq_pulse <= pulse_nxt;
      drop_err  <= drop_nxt;
    end
  end

endmodule

// File: rtl/irqdel_msg_dispatch.sv
module irqdel_msg_dispatch
  import irqdel_pkg::*;
#(
  parameter int unsigned NUM_VEC = 5,
  parameter int unsigned VEC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] msg_set,
  output logic [VEC_W-1:0]   look_idx,
  input  vec_entry_t         look_entry,
  output logic [NUM_VEC-1:0] pend_q,
  output logic [NUM_VEC-1:0] grant,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);

  logic fire;

  function automatic logic [NUM_VEC-1:0] lowest_set(input logic [NUM_VEC-1:0] v);
    return v & (~v + NUM_VEC'(1));
  endfunction

  function automatic logic [VEC_W-1:0] onehot_index(input logic [NUM_VEC-1:0] oh);
    logic [VEC_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < NUM_VEC; i++)
      if (oh[i]) idx = idx | VEC_W'(i);
    return idx;
  endfunction

  assign grant    = msg_valid ? '0 : lowest_set(pend_q);
  assign fire     = |grant;
  assign look_idx = onehot_index(grant);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      pend_q <= (pend_q & ~grant) | msg_set;
      if (msg_valid && msg_ready) begin
        msg_valid <= 1'b0;
      end else if (fire) begin
        msg_valid <= 1'b1;
        msg_addr  <= entry_target(look_entry);
        msg_data  <= look_entry.data;
      end
    end
  end

endmodule

// File: rtl/iommu_irq_deliver.sv
module iommu_irq_deliver
  import irqdel_pkg::*;
#(
  parameter int unsigned NUM_VEC    = 5,
  parameter int unsigned NUM_WIRED  = 4,
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned PBA_OFFSET = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wired_mode,
  input  logic                 ntf_valid,
  input  logic [2:0]           ntf_vec,
  input  logic                 reg_valid,
  input  logic                 reg_write,
  input  logic                 reg_wide,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [63:0]          reg_wdata,
  output logic [63:0]          reg_rdata,
  output logic [NUM_WIRED-1:0] irq_pulse,
  output logic                 drop_err,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [63:0]          msg_addr,
  output logic [31:0]          msg_data
);

  localparam int unsigned VEC_W = 3;

  logic [NUM_VEC-1:0] msg_set;
  logic [NUM_VEC-1:0] pend_q;
  logic [NUM_VEC-1:0] grant;
  logic [VEC_W-1:0]   look_idx;
  vec_entry_t         look_entry;

  irqdel_vec_table #(
    .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .PBA_OFFSET(PBA_OFFSET), .VEC_W(VEC_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_wide(reg_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pend_bits(pend_q), .look_idx(look_idx), .look_entry(look_entry)
  );

  irqdel_notify_route #(
    .NUM_VEC(NUM_VEC), .NUM_WIRED(NUM_WIRED), .VEC_W(VEC_W)
  ) u_route (
    .clk(clk), .rst_n(rst_n), .wired_mode(wired_mode),
    .ntf_valid(ntf_valid), .ntf_vec(ntf_vec),
    .irq_pulse(irq_pulse), .drop_err(drop_err), .msg_set(msg_set)
  );

  irqdel_msg_dispatch #(
    .NUM_VEC(NUM_VEC), .VEC_W(VEC_W)
  ) u_disp (
    .clk(clk), .rst_n(rst_n), .msg_set(msg_set),
    .look_idx(look_idx), .look_entry(look_entry),
    .pend_q(pend_q), .grant(grant),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

endmodule

// File: rtl/irqdel_checker.sv
module irqdel_checker #(
  parameter int unsigned NUM_VEC   = 5,
  parameter int unsigned NUM_WIRED = 4,
  parameter int unsigned VEC_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wired_mode,
  input logic                 ntf_valid,
  input logic [VEC_W-1:0]     ntf_vec,
  input logic [NUM_WIRED-1:0] irq_pulse,
  input logic                 drop_err,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [63:0]          msg_addr,
  input logic [31:0]          msg_data,
  input logic [NUM_VEC-1:0]   pend_q,
  input logic [NUM_VEC-1:0]   grant
);

  AST_PULSE_ON_NOTIFY: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && wired_mode && (32'(ntf_vec) < NUM_WIRED)) |=>
      (irq_pulse == (NUM_WIRED'(1) << $past(ntf_vec)))); // R5

  AST_PULSE_NEEDS_NOTIFY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse != '0) |-> $past(ntf_valid && wired_mode)); // R5

  AST_WIRED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && wired_mode && (32'(ntf_vec) >= NUM_WIRED)) |=>
      (drop_err && (irq_pulse == '0))); // R6

  AST_MSG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && !wired_mode && (32'(ntf_vec) >= NUM_VEC)) |=> drop_err); // R11

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=>
      (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R8

  AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (grant == '0)); // R8

  AST_GRANT_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(grant) && ((grant & ~pend_q) == '0))); // R9

endmodule

bind iommu_irq_deliver irqdel_checker #(
  .NUM_VEC(NUM_VEC), .NUM_WIRED(NUM_WIRED), .VEC_W(VEC_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wired_mode(wired_mode),
  .ntf_valid(ntf_valid), .ntf_vec(ntf_vec),
  .irq_pulse(irq_pulse), .drop_err(drop_err),
  .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data),
  .pend_q(pend_q), .grant(grant)
);

// File: tb/iommu_irq_deliver_tb_top.sv
module iommu_irq_deliver_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wired_mode = 1'b0;
  logic        ntf_valid = 1'b0;
  logic [2:0]  ntf_vec = '0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic        reg_wide = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [3:0]  irq_pulse;
  logic        drop_err;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  iommu_irq_deliver dut_i (
    .clk(clk), .rst_n(rst_n), .wired_mode(wired_mode),
    .ntf_valid(ntf_valid), .ntf_vec(ntf_vec),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_wide(reg_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pulse(irq_pulse), .drop_err(drop_err),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  // {ctrl, data, addr_hi, addr_lo} per vector
  localparam logic [127:0] VTAB [5] = '{
    128'h00000000_D0000010_00000001_24000000,
    128'h00000001_D1110021_00000000_24001004,
    128'h00000000_D2220032_000000FF_FFFFFFFC,
    128'h00000000_00000003_80000000_00000040,
    128'h00000001_FFFFFFFF_12345678_9ABCDEF0
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input logic [63:0] d, input logic wide);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_wide = wide;
    reg_addr = 9'(addr); reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; reg_wide = 1'b0;
  endtask

  task automatic bus_read(input int addr, input logic wide, output logic [63:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_wide = wide; reg_addr = 9'(addr);
    #1;
    d = reg_rdata;
    reg_valid = 1'b0; reg_wide = 1'b0;
  endtask

  task automatic notify(input int v);
    @(negedge clk);
    ntf_valid = 1'b1; ntf_vec = 3'(v);
    @(negedge clk);
    ntf_valid = 1'b0;
  endtask

  task automatic expect_msg(input string tag, input logic [63:0] a, input logic [31:0] d);
    int waited;
    waited = 0;
    while (!msg_valid && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    chk({tag, " valid"}, 64'(msg_valid), 64'h1);
    chk({tag, " addr"}, msg_addr, a);
    chk({tag, " data"}, 64'(msg_data), 64'(d));
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 irq_pulse", 64'(irq_pulse), 64'h0);
    chk("R1 drop_err", 64'(drop_err), 64'h0);
    chk("R1 msg_valid", 64'(msg_valid), 64'h0);
    for (int i = 0; i < 5; i++) begin
      bus_read(16*i, 1'b1, rd); chk("R1 entry words 0/1", rd, 64'h0);
      bus_read(16*i + 8, 1'b1, rd); chk("R1 entry words 2/3", rd, 64'h0);
    end
    bus_read(256, 1'b1, rd); chk("R1 pending window", rd, 64'h0);

    // R2 R3: program and read back the table, mixed access widths
    for (int i = 0; i < 5; i++) begin
      bus_write(16*i, {32'hDEADBEEF, VTAB[i][31:0]}, 1'b0);
      bus_write(16*i + 4, 64'(VTAB[i][63:32]), 1'b0);
      bus_write(16*i + 8, VTAB[i][127:64], 1'b1);
    end
    for (int i = 0; i < 5; i++) begin
      bus_read(16*i, 1'b1, rd);     chk("R3 wide read address pair", rd, VTAB[i][63:0]);
      bus_read(16*i + 8, 1'b0, rd); chk("R2 narrow read data word", rd, 64'(VTAB[i][95:64]));
      bus_read(16*i + 12, 1'b0, rd); chk("R2 narrow read ctrl word", rd, 64'(VTAB[i][127:96]));
      bus_read(16*i + 4, 1'b0, rd); chk("R2 narrow write ignores upper lane", rd, 64'(VTAB[i][63:32]));
    end

    // R5: wired pulses
    wired_mode = 1'b1;
    for (int v = 0; v < 4; v++) begin
      notify(v);
      chk("R5 pulse line", 64'(irq_pulse), 64'(4'b1 << v));
      chk("R5 no error", 64'(drop_err), 64'h0);
      @(negedge clk);
      chk("R5 pulse width", 64'(irq_pulse), 64'h0);
    end

    // R6: wired vector beyond line count
    notify(4);
    chk("R6 drop_err", 64'(drop_err), 64'h1);
    chk("R6 no pulse", 64'(irq_pulse), 64'h0);
    @(negedge clk);
    chk("R6 drop_err width", 64'(drop_err), 64'h0);
    chk("R6 no write", 64'(msg_valid), 64'h0);

    // R7: message writes, exact latency
    wired_mode = 1'b0;
    for (int v = 0; v < 5; v++) begin
      notify(v);
      chk("R7 not yet valid", 64'(msg_valid), 64'h0);
      chk("R7 no pulse", 64'(irq_pulse), 64'h0);
      @(negedge clk);
      chk("R7 valid at second edge", 64'(msg_valid), 64'h1);
      expect_msg("R7 write", VTAB[v][63:0], VTAB[v][95:64]);
    end

    // R9 R10 R8: queued ordering, coalescing, hold while stalled
    notify(2);
    notify(4);
    notify(1);
    notify(3);
    bus_read(256, 1'b0, rd); chk("R9 pending bits", rd, 64'h1A);
    notify(1);
    bus_read(256, 1'b0, rd); chk("R10 pending unchanged", rd, 64'h1A);
    bus_write(256, 64'hFFFFFFFF_FFFFFFFF, 1'b1);
    bus_read(256, 1'b1, rd); chk("R4 write ignored", rd, 64'h1A);
    bus_write(16*2 + 8, 64'h55555555, 1'b0);
    chk("R8 still valid", 64'(msg_valid), 64'h1);
    chk("R8 data held", 64'(msg_data), 64'(VTAB[2][95:64]));
    chk("R8 addr held", msg_addr, VTAB[2][63:0]);
    expect_msg("R9 first vec2", VTAB[2][63:0], VTAB[2][95:64]);
    expect_msg("R9 then vec1", VTAB[1][63:0], VTAB[1][95:64]);
    expect_msg("R9 then vec3", VTAB[3][63:0], VTAB[3][95:64]);
    expect_msg("R9 then vec4", VTAB[4][63:0], VTAB[4][95:64]);
    repeat (4) @(negedge clk);
    chk("R10 single write for vec1", 64'(msg_valid), 64'h0);
    bus_read(256, 1'b0, rd); chk("R4 pending drained", rd, 64'h0);

    // R11: message vector out of range
    notify(6);
    chk("R11 drop_err", 64'(drop_err), 64'h1);
    @(negedge clk);
    chk("R11 no write", 64'(msg_valid), 64'h0);
    bus_read(256, 1'b0, rd); chk("R11 nothing pending", rd, 64'h0);

    // R12: unmapped addresses
    bus_write(80, 64'h01234567_89ABCDEF, 1'b1);
    bus_read(80, 1'b1, rd); chk("R12 gap reads zero", rd, 64'h0);
    bus_write(300, 64'hCAFEF00D, 1'b0);
    bus_read(300, 1'b0, rd); chk("R12 high gap reads zero", rd, 64'h0);
    bus_read(64, 1'b1, rd); chk("R12 last entry untouched", rd, VTAB[4][63:0]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule